// File: doc/BRIEF.md
# Interrupt Register Access Trap Decoder

This block judges a single system-register access aimed at the processor's interrupt controller interface. For each request it returns one of three outcomes: the access may proceed, it must be diverted to the highest exception level, or it raises an ordinary trap. The outcome depends on several inputs:

- the exception level of the access;
- the security state below the top level;
- two routing bits from the secure configuration register;
- two hypervisor override bits;
- the execution state of the current code and of the top level;
- a register class supplied by the decoder that sits before this block.

The upstream decoder assigns each register to a class. The priority-mask and banked control registers use the combined class. The group-0 binary-point, group-0 active-priority and group-0 enable registers use the FIQ class. All group-1 registers use the IRQ class.

A request is presented together with a one-cycle valid strobe. On the next clock edge the decision is captured in a register, and a one-cycle response pulse accompanies it. Between strobes the captured result is held.

Top module: `ictrap_decoder`

## Requirements
- R1: While reset is high, `rsp_valid` reads 0 and `rsp_code` reads 2'b00 (OK) at the following edge.
- R2: A request with `req_valid` high produces `rsp_valid` high for exactly the next cycle. Without a strobe, `rsp_valid` is 0 and `rsp_code` keeps its previous value.
- R3: The trap check applies only when the routing bits named by the class are all set. Class 2'b01 (IRQ) needs `scr_route_irq`. Class 2'b10 (FIQ) needs `scr_route_fiq`. Class 2'b11 (both) needs both bits. Class 2'b00 never applies. A check that does not apply gives OK.
- R4: At level 1 (`req_level`=1), an applicable check gives trap-to-top in two cases: when `req_sec_low` is set, or when the override bits of the class are all clear. Those override bits are `hyp_irq_ovr` for IRQ, `hyp_fiq_ovr` for FIQ, and both bits for the combined class. Otherwise the result is OK.
- R5: At level 2, an applicable check always gives trap-to-top.
- R6: At level 3, an applicable check gives trap-to-top only when `cur_is64` and `cur_monitor` are both 0. Otherwise the result is OK.
- R7: Level 0 always gives OK.
- R8: When `top_is64` is 0, a trap-to-top result is replaced by an ordinary trap. OK results are unaffected.
- R9: Result codes are 2'b00 OK, 2'b01 trap-to-top and 2'b10 ordinary trap. The code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_level | input | 2 | Exception level of the access |
| req_sec_low | input | 1 | Secure state applies below the top level |
| req_class | input | 2 | Register class: 1 IRQ, 2 FIQ, 3 both, 0 none |
| scr_route_irq | input | 1 | IRQ routing bit of the secure configuration |
| scr_route_fiq | input | 1 | FIQ routing bit of the secure configuration |
| hyp_irq_ovr | input | 1 | Hypervisor IRQ override |
| hyp_fiq_ovr | input | 1 | Hypervisor FIQ override |
| top_is64 | input | 1 | Top exception level runs in 64-bit state |
| cur_is64 | input | 1 | Current code runs in 64-bit state |
| cur_monitor | input | 1 | Current code is in monitor mode |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_code | output | 2 | Registered result code |

## Verification
Two things can happen in the same cycle: a result pulse is presented while a new request is being captured. The bench provokes this by holding the strobe high across the whole vector table, so that each cycle both shows the previous result and loads the next one. It then compares every cycle's code against the expected value for its own vector. The downgrade of R8 coinciding with a level-specific trap is judged the same way, by vectors that trap at levels 1, 2 and 3 with a 32-bit top level.

// File: rtl/ictrap_pkg.sv
package ictrap_pkg;

    localparam int LVL_W  = 2;
    localparam int CODE_W = 2;
    localparam int CLS_W  = 2;

    typedef enum logic [CODE_W-1:0] {
        RC_OK       = 2'b00,
        RC_TRAP_TOP = 2'b01,
        RC_TRAP     = 2'b10
    } rcode_e;

    typedef enum logic [CLS_W-1:0] {
        CLS_NONE = 2'b00,
        CLS_IRQ  = 2'b01,
        CLS_FIQ  = 2'b10,
        CLS_BOTH = 2'b11
    } rclass_e;

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic             sec_low;
        logic             hyp_irq;
        logic             hyp_fiq;
        logic             cur_is64;
        logic             cur_mon;
    } ctx_t;

    // routing bits selected by the class must all be set
    function automatic logic route_applies(rclass_e c, logic ri, logic rf);
        case (c)
            CLS_IRQ:  return ri;
            CLS_FIQ:  return rf;
            CLS_BOTH: return ri & rf;
            default:  return 1'b0;
        endcase
    endfunction

    // override bits selected by the class are all clear
    function automatic logic ovr_all_clear(rclass_e c, logic hi, logic hf);
        case (c)
            CLS_IRQ:  return ~hi;
            CLS_FIQ:  return ~hf;
            CLS_BOTH: return ~hi & ~hf;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ictrap_route_gate.sv
module ictrap_route_gate
    import ictrap_pkg::*;
(
    input  rclass_e cls,
    input  logic    route_irq,
    input  logic    route_fiq,
    output logic    active
);
    always_comb active = route_applies(cls, route_irq, route_fiq);
endmodule

// File: rtl/ictrap_level_eval.sv
module ictrap_level_eval
    import ictrap_pkg::*;
(
    input  ctx_t    ctx,
    input  rclass_e cls,
    input  logic    active,
    output rcode_e  raw
);
    logic l1_trap;

    always_comb begin
        l1_trap = ctx.sec_low | ovr_all_clear(cls, ctx.hyp_irq, ctx.hyp_fiq);
        raw     = RC_OK;
        if (active) begin
            case (ctx.level)
                LVL_W'(1): raw = l1_trap ? RC_TRAP_TOP : RC_OK;
                LVL_W'(2): raw = RC_TRAP_TOP;
                LVL_W'(3): raw = (!ctx.cur_is64 && !ctx.cur_mon) ? RC_TRAP_TOP : RC_OK;
                default:   raw = RC_OK;
            endcase
        end
    end
endmodule

// File: rtl/ictrap_target_fold.sv
module ictrap_target_fold
    import ictrap_pkg::*;
(
    input  rcode_e raw,
    input  logic   top_is64,
    output rcode_e folded
);
    always_comb folded = (raw == RC_TRAP_TOP && !top_is64) ? RC_TRAP : raw;
endmodule

// File: rtl/ictrap_decoder.sv
module ictrap_decoder
    import ictrap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [LVL_W-1:0]  req_level,
    input  logic              req_sec_low,
    input  logic [CLS_W-1:0]  req_class,
    input  logic              scr_route_irq,
    input  logic              scr_route_fiq,
    input  logic              hyp_irq_ovr,
    input  logic              hyp_fiq_ovr,
    input  logic              top_is64,
    input  logic              cur_is64,
    input  logic              cur_monitor,
    output logic              rsp_valid,
    output logic [CODE_W-1:0] rsp_code
);
    rclass_e cls;
    ctx_t    ctx;
    logic    active;
    rcode_e  raw_code;
    rcode_e  final_code;
    rcode_e  code_q;

    always_comb begin
        cls          = rclass_e'(req_class);
        ctx.level    = req_level;
        ctx.sec_low  = req_sec_low;
        ctx.hyp_irq  = hyp_irq_ovr;
        ctx.hyp_fiq  = hyp_fiq_ovr;
        ctx.cur_is64 = cur_is64;
        ctx.cur_mon  = cur_monitor;
    end

    ictrap_route_gate u_gate (
        .cls       (cls),
        .route_irq (scr_route_irq),
        .route_fiq (scr_route_fiq),
        .active    (active)
    );

    ictrap_level_eval u_eval (
        .ctx    (ctx),
        .cls    (cls),
        .active (active),
        .raw    (raw_code)
    );

    ictrap_target_fold u_fold (
        .raw      (raw_code),
        .top_is64 (top_is64),
        .folded   (final_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            code_q    <= RC_OK;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) code_q <= final_code;
        end
    end

    assign rsp_code = code_q;

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!rsp_valid && rsp_code == RC_OK));
    // R2
    a_r2_pulse_on: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r2_pulse_off: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    a_r2_code_hold: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(rsp_code));
    // R3
    a_r3_irq_unrouted: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_class == CLS_IRQ && !scr_route_irq) |=> rsp_code == RC_OK);
    // R5
    a_r5_level2_trap: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_level == 2'd2 && req_class == CLS_BOTH &&
         scr_route_irq && scr_route_fiq && top_is64) |=> rsp_code == RC_TRAP_TOP);
    // R7
    a_r7_level0_ok: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_level == 2'd0) |=> rsp_code == RC_OK);
    // R8
    a_r8_no_top_when32: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !top_is64) |=> rsp_code != RC_TRAP_TOP);
    // R9
    a_r9_legal_code: assert property (@(posedge clk) disable iff (rst)
        rsp_code != 2'b11);

endmodule

// File: tb/ictrap_decoder_test.sv
`timescale 1ns/1ps
module ictrap_decoder_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_level = 2'd0;
    logic       req_sec_low = 1'b0;
    logic [1:0] req_class = 2'd0;
    logic       scr_route_irq = 1'b0;
    logic       scr_route_fiq = 1'b0;
    logic       hyp_irq_ovr = 1'b0;
    logic       hyp_fiq_ovr = 1'b0;
    logic       top_is64 = 1'b1;
    logic       cur_is64 = 1'b1;
    logic       cur_monitor = 1'b0;
    logic       rsp_valid;
    logic [1:0] rsp_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    ictrap_decoder uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
        .req_sec_low(req_sec_low), .req_class(req_class),
        .scr_route_irq(scr_route_irq), .scr_route_fiq(scr_route_fiq),
        .hyp_irq_ovr(hyp_irq_ovr), .hyp_fiq_ovr(hyp_fiq_ovr),
        .top_is64(top_is64), .cur_is64(cur_is64), .cur_monitor(cur_monitor),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code)
    );

    // packing: [17:16] expected, [15:12] requirement, [11:10] level, [9] sec,
    // [8] route irq, [7] route fiq, [6] hyp irq, [5] hyp fiq, [4] top64,
    // [3] cur64, [2] monitor, [1:0] class
    function automatic logic [17:0] v(input int e, input int r, input int l,
        input bit s, input bit ri, input bit rf, input bit hi, input bit hf,
        input bit t, input bit a, input bit m, input int c);
        return {2'(e), 4'(r), 2'(l), s, ri, rf, hi, hf, t, a, m, 2'(c)};
    endfunction

    localparam int NV = 22;
    localparam logic [17:0] VECS [NV] = '{
        v(1,4,1, 0,1,0,0,0, 1,1,0, 1),  // R4 irq, override clear
        v(0,4,1, 0,1,0,1,0, 1,1,0, 1),  // R4 irq, override set
        v(1,4,1, 1,1,0,1,0, 1,1,0, 1),  // R4 secure below top
        v(0,3,1, 0,0,1,0,0, 1,1,0, 1),  // R3 irq unrouted
        v(1,4,1, 0,0,1,1,0, 1,1,0, 2),  // R4 fiq, fiq override clear
        v(0,4,1, 0,0,1,0,1, 1,1,0, 2),  // R4 fiq override set
        v(0,4,1, 0,1,1,1,0, 1,1,0, 3),  // R4 both, one override set
        v(1,4,1, 0,1,1,0,0, 1,1,0, 3),  // R4 both, both clear
        v(0,3,1, 0,1,0,0,0, 1,1,0, 3),  // R3 both needs both routes
        v(1,5,2, 0,1,0,0,0, 1,1,0, 1),  // R5
        v(0,3,2, 0,0,1,0,0, 1,1,0, 1),  // R3 level 2 unrouted
        v(1,5,2, 0,0,1,1,1, 1,1,0, 2),  // R5 overrides irrelevant
        v(1,6,3, 0,1,1,0,0, 1,0,0, 3),  // R6 32-bit, not monitor
        v(0,6,3, 0,1,1,0,0, 1,1,0, 3),  // R6 64-bit
        v(0,6,3, 0,1,1,0,0, 1,0,1, 3),  // R6 monitor
        v(2,8,2, 0,1,0,0,0, 0,1,0, 1),  // R8 level 2 downgrade
        v(2,8,1, 1,0,1,1,1, 0,1,0, 2),  // R8 level 1 downgrade
        v(2,8,3, 0,1,1,0,0, 0,0,0, 3),  // R8 level 3 downgrade
        v(0,7,0, 1,1,1,0,0, 1,0,0, 3),  // R7
        v(0,3,2, 0,1,1,0,0, 1,1,0, 0),  // R3 class none
        v(0,8,1, 0,1,0,1,0, 0,1,0, 1),  // R8 OK unchanged
        v(0,8,2, 0,0,0,0,0, 0,1,0, 1)   // R8 inactive, 32-bit top
    };

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic [17:0] x);
        req_level     = x[11:10];
        req_sec_low   = x[9];
        scr_route_irq = x[8];
        scr_route_fiq = x[7];
        hyp_irq_ovr   = x[6];
        hyp_fiq_ovr   = x[5];
        top_is64      = x[4];
        cur_is64      = x[3];
        cur_monitor   = x[2];
        req_class     = x[1:0];
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid", {1'b0, rsp_valid}, 2'd0);
        check("R1 code", rsp_code, 2'd0);
        @(negedge clk) rst = 1'b0;

        // back-to-back table walk: each cycle shows one result, captures the next
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VECS[i]);
            req_valid = 1'b1;
            @(posedge clk);
            #1;
            check($sformatf("R%0d vec %0d", VECS[i][15:12], i), rsp_code, VECS[i][17:16]);
            check("R2 pulse", {1'b0, rsp_valid}, 2'd1);
        end

        // R2: no strobe, code held at last result despite trapping inputs
        @(negedge clk);
        req_valid = 1'b0;
        apply(v(0,0,2, 0,1,1,0,0, 1,1,0, 3));
        @(posedge clk);
        #1;
        check("R2 idle valid", {1'b0, rsp_valid}, 2'd0);
        check("R2 idle hold", rsp_code, 2'd0);

        // R2: single pulse width
        @(negedge clk) req_valid = 1'b1;
        @(negedge clk) req_valid = 1'b0;
        #1;
        check("R2 single pulse", {1'b0, rsp_valid}, 2'd1);
        check("R5 single", rsp_code, 2'd1);
        @(posedge clk);
        #1;
        check("R2 pulse ends", {1'b0, rsp_valid}, 2'd0);
        check("R2 code kept", rsp_code, 2'd1);

        // R1: reset mid-run clears held trap code
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 mid reset", rsp_code, 2'd0);
        // R9: no code 2'b11 was seen at the end
        check("R9 legal", {1'b0, rsp_code == 2'b11}, 2'd0);
        @(negedge clk) rst = 1'b0;

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule